// File: doc/BRIEF.md
# Real-Time Clock Tick and Alarm Interrupt Unit

This unit produces the interrupt of a real-time clock. It does not keep time. It watches the eight calendar counters that sit next to it, together with a one-cycle strobe that each counter pulses when it advances. From these it raises an interrupt for two kinds of event.

The first kind is the advance of any counter that software has enabled. The second is an alarm: a programmed date and time, in which any field can be left out of the comparison. Both events latch into a two-bit status register. Software clears a status bit by writing 1 to it. A value read from the register can therefore be written straight back to acknowledge exactly the events that were seen.

The alarm latches only on the cycle where the compare result goes from false to true. A match that stays true while software clears the flag does not assert the flag again. All configuration sits behind a small synchronous write port with a combinational read port.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, every readable register holds zero and `irq` is low.
- R2: The register addresses are: status at 0, increment enable at 1, alarm mask at 2, and alarm field i at 8+i. Field bit order is 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. Written values read back unchanged, with alarm fields holding FIELD_W bits.
- R3: Suppose increment-enable bit i is set and `cnt_inc[i]` is high in a cycle. Then status bit 0 (the increment flag) is 1 after that clock edge.
- R4: A `cnt_inc[i]` pulse whose enable bit is clear leaves status bit 0 at 0.
- R5: Status bit 1 (the alarm flag) is set when every alarm field whose mask bit is 0 equals its counter. A mask bit of 1 removes that field from the comparison.
- R6: The alarm flag is set only on the edge where the compare result changes from false to true. A match that persists does not set the flag again after it has been cleared.
- R7: With all eight mask bits set, the compare result is always true, so it gives at most one alarm after reset.
- R8: Writing the status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: If a hardware set and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 8*FIELD_W | Current counter values, field i at bits [i*FIELD_W +: FIELD_W] |
| cnt_inc | input | 8 | One-cycle advance strobe per counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach is a fresh false-to-true edge of the alarm compare for one chosen mask pattern. Writing the mask or the alarm fields can change the compare result by itself. For that reason the bench handles each of the 256 mask patterns in a fixed order. It first drives the counters to a state that mismatches every field. It then acknowledges whatever flag the reconfiguration left behind. Only then does it apply counters that differ from the alarm in one field alone. This makes the expected flag equal to that field's mask bit. For the all-masked pattern the expected flag is 0, because the compare result was already true.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned NFIELD      = 8;
  localparam int unsigned NSRC        = 2;
  localparam int unsigned SRC_TICK    = 0;
  localparam int unsigned SRC_ALARM   = 1;
  localparam logic [3:0]  ADDR_STATUS = 4'd0;
  localparam logic [3:0]  ADDR_INCEN  = 4'd1;
  localparam logic [3:0]  ADDR_MASK   = 4'd2;
endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NSRC-1:0]           status,
  output logic [NFIELD-1:0]         inc_en,
  output logic [NFIELD-1:0]         mask,
  output logic [NFIELD*FIELD_W-1:0] alarm_flat,
  output logic [DATA_W-1:0]         rdata
);
  logic [NFIELD-1:0]  inc_en_q, inc_en_d;
  logic [NFIELD-1:0]  mask_q, mask_d;
  logic [FIELD_W-1:0] alarm_q [NFIELD];
  logic [FIELD_W-1:0] alarm_d [NFIELD];
  logic               alarm_sel;
  logic [2:0]         idx;

  assign alarm_sel = addr[3];
  assign idx       = addr[2:0];

  always_comb begin
    inc_en_d = inc_en_q;
    mask_d   = mask_q;
    for (int i = 0; i < NFIELD; i++) alarm_d[i] = alarm_q[i];
    if (wr_en) begin
      if (alarm_sel) alarm_d[idx] = wdata[FIELD_W-1:0];
      else if (addr == ADDR_INCEN) inc_en_d = wdata[NFIELD-1:0];
      else if (addr == ADDR_MASK)  mask_d   = wdata[NFIELD-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_en_q <= '0;
      mask_q   <= '0;
      for (int i = 0; i < NFIELD; i++) alarm_q[i] <= '0;
    end else if (wr_en) begin
      inc_en_q <= inc_en_d;
      mask_q   <= mask_d;
      for (int i = 0; i < NFIELD; i++) alarm_q[i] <= alarm_d[i];
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_flat
    assign alarm_flat[g*FIELD_W +: FIELD_W] = alarm_q[g];
  end

  assign inc_en = inc_en_q;
  assign mask   = mask_q;

  always_comb begin
    rdata = '0;
    if (alarm_sel) rdata[FIELD_W-1:0] = alarm_q[idx];
    else if (addr == ADDR_STATUS) rdata[NSRC-1:0]   = status;
    else if (addr == ADDR_INCEN)  rdata[NFIELD-1:0] = inc_en_q;
    else if (addr == ADDR_MASK)   rdata[NFIELD-1:0] = mask_q;
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_MASK) |=> (mask == $past(wdata[NFIELD-1:0])));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FIELD_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NFIELD*FIELD_W-1:0] cnt_flat,
  input  logic [NFIELD*FIELD_W-1:0] alarm_flat,
  input  logic [NFIELD-1:0]         mask,
  output logic                      rise
);
  logic [NFIELD-1:0] fld_ok;
  logic              match;
  logic              prev_q;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign fld_ok[g] = mask[g] |
      (cnt_flat[g*FIELD_W +: FIELD_W] == alarm_flat[g*FIELD_W +: FIELD_W]);
  end

  assign match = &fld_ok;
  assign rise  = match & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= match;
  end

  // R6
  rise_then_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> prev_q);
  // R7
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> match);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] sw_clr,
  output logic [NSRC-1:0] status
);
  logic [NSRC-1:0] stat_q, stat_d;
  logic            upd;

  assign upd    = |hw_set | |sw_clr;
  assign stat_d = (stat_q & ~sw_clr) | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign status = stat_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[g] |=> status[g]);
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[g] && !hw_set[g]) |=> !status[g]);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_clr[g] && !hw_set[g]) |=> $stable(status[g]));
  end
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [8*FIELD_W-1:0]      cnt_val,
  input  logic [7:0]                cnt_inc,
  input  logic                      reg_wr,
  input  logic [3:0]                reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      irq
);
  logic [NFIELD-1:0]         inc_en;
  logic [NFIELD-1:0]         mask;
  logic [NFIELD*FIELD_W-1:0] alarm_flat;
  logic [NSRC-1:0]           status;
  logic [NSRC-1:0]           hw_set;
  logic [NSRC-1:0]           sw_clr;
  logic                      alarm_rise;

  rtc_cfg_regs #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .inc_en(inc_en), .mask(mask),
    .alarm_flat(alarm_flat), .rdata(reg_rdata)
  );

  rtc_alarm_cmp #(.FIELD_W(FIELD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_val), .alarm_flat(alarm_flat),
    .mask(mask), .rise(alarm_rise)
  );

  assign hw_set[SRC_TICK]  = |(cnt_inc & inc_en);
  assign hw_set[SRC_ALARM] = alarm_rise;
  assign sw_clr = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata[NSRC-1:0] : '0;

  rtc_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_clr(sw_clr), .status(status)
  );

  assign irq = |status;

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|hw_set));
  // R3
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cnt_inc & inc_en)) |=> irq);
endmodule

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
  localparam int FW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [8*FW-1:0] cnt_val;
  logic [7:0]    cnt_inc;
  logic          reg_wr;
  logic [3:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int vec = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rtc_irq_unit #(.FIELD_W(FW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_inc(cnt_inc),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [FW-1:0] aval(int i);
    return FW'(i * 7 + 3);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_cnt(int diff_mask);
    for (int i = 0; i < 8; i++)
      cnt_val[i*FW +: FW] = diff_mask[i] ? aval(i) + FW'(1) : aval(i);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; cnt_val = '1; cnt_inc = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, d); check("R1 status", d, 0);
    rd(4'd1, d); check("R1 incen", d, 0);
    rd(4'd2, d); check("R1 mask", d, 0);
    for (int i = 0; i < 8; i++) begin rd(4'(8+i), d); check("R1 alarm", d, 0); end
    check("R1 irq", {31'd0, irq}, 0);

    // R2 readback
    for (int i = 0; i < 8; i++) wr(4'(8+i), DW'(aval(i)) | 32'hF000_0000);
    for (int i = 0; i < 8; i++) begin rd(4'(8+i), d); check("R2 alarm", d, DW'(aval(i))); end
    wr(4'd1, 32'h1A5); rd(4'd1, d); check("R2 incen", d, 32'hA5);
    wr(4'd2, 32'h15A); rd(4'd2, d); check("R2 mask", d, 32'h5A);
    wr(4'd2, 32'h0);
    set_cnt(8'hFF);
    wr(4'd0, 32'h3);

    // R3/R4/R10 sweep of enable bit against strobed counter
    for (int e = 0; e < 8; e++) begin
      wr(4'd1, DW'(1 << e));
      for (int f = 0; f < 8; f++) begin
        wr(4'd0, 32'h3);
        @(negedge clk); cnt_inc = 8'(1 << f);
        @(negedge clk); cnt_inc = '0;
        rd(4'd0, d);
        check(e == f ? "R3 tick" : "R4 disabled", d, (e == f) ? 1 : 0);
        check("R10 irq", {31'd0, irq}, (e == f) ? 1 : 0);
      end
    end

    // R9 set wins over same-cycle clear
    wr(4'd1, 32'hFF);
    @(negedge clk); cnt_inc = 8'h01;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h3;
    @(negedge clk); cnt_inc = '0; reg_wr = 1'b0;
    rd(4'd0, d); check("R9 set wins", d, 1);
    wr(4'd1, 32'h0);

    // R5/R6/R7 sweep of mask patterns, single mismatching field
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 8; k++) begin
        wr(4'd2, DW'(m));
        @(negedge clk); set_cnt(8'hFF);
        @(negedge clk);
        wr(4'd0, 32'h3);
        set_cnt(1 << k);
        @(negedge clk);
        rd(4'd0, d);
        if (m == 255) check("R7 all masked", d, 0);
        else check("R5 alarm", d, m[k] ? 2 : 0);
        check("R10 irq", {31'd0, irq}, (m != 255 && m[k]) ? 1 : 0);
      end
    end

    // R6 persistent match not re-raised; R8 write-back semantics
    wr(4'd2, 32'h0);
    set_cnt(8'hFF); @(negedge clk);
    wr(4'd0, 32'h3);
    set_cnt(0); @(negedge clk);
    rd(4'd0, d); check("R5 full match", d, 2);
    wr(4'd0, 32'h2);
    repeat (4) @(negedge clk);
    rd(4'd0, d); check("R6 no re-raise", d, 0);
    wr(4'd1, 32'h01);
    set_cnt(8'hFF); @(negedge clk);
    set_cnt(0); cnt_inc = 8'h01;
    @(negedge clk); cnt_inc = '0;
    rd(4'd0, d); check("R8 both set", d, 3);
    wr(4'd0, 32'h1);
    rd(4'd0, d); check("R8 clear bit0 only", d, 2);
    wr(4'd0, 32'h0);
    rd(4'd0, d); check("R8 zero write", d, 2);
    wr(4'd0, 32'h2);
    rd(4'd0, d); check("R8 clear bit1", d, 0);
    check("R10 irq low", {31'd0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule